// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block fronts an array of one-time-programmable fuse words behind a small 32-bit register window. Software loads a word address, a bit index and a single data bit into separate registers, and sets three independent enable bits. It then reads the selected fuse word through a read-only output register. While any of the three enables is clear, that register returns the fixed pattern 0x000000FF and no fuse data.

Programming is one bit per strobe. Writing the write-enable register with its bit 0 set burns the chosen bit, provided the redundancy-select register is zero. A per-bit written map records every bit that has been burned. A second attempt on the same bit is refused: the fuse stays unchanged and an error flag pulses. At reset every fuse word reads as all ones, except a serial number and its bitwise complement, which sit in two adjacent words. The written map starts empty.

Every request receives a registered response one cycle later. Accesses to holes in the window, misaligned accesses and accesses that are not 32 bits wide are rejected with an error pulse.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: A read of the data-out register (offset 0x18) returns the fuse word selected by the address register when bit 0 of the chip-enable (0x0C), strobe (0x1C) and trim (0x34) registers are all 1. If any of the three is 0, the read returns 0x000000FF.
- R2: The address register (0x00) stores only write-data bits 11:0. A read of it returns those bits with bits 31:12 as zero.
- R3: A write to the write-enable register (0x38) with data bit 0 equal to 1, while the redundancy-select register (0x08) is zero, sets bit BITSEL[4:0] (bit-select register, 0x04) of the addressed word to bit 0 of the data-in register (0x14). The write-enable register reads back only its bit 0.
- R4: While the redundancy-select register is nonzero, a write-enable strobe leaves the fuse word unchanged, does not mark the bit as written and raises no error.
- R5: A programming attempt on a bit already marked written leaves the word unchanged. prog_err_o is 1 in the response cycle of that write and 0 after a successful program.
- R6: After reset every fuse word reads 0xFFFFFFFF, except word SERIAL_ADDR, which reads SERIAL, and word SERIAL_ADDR+1, which reads ~SERIAL. No bit is marked written.
- R7: Writes to the data-out register have no effect. The fourteen other registers read back the value last written to them (with the masking of R2 and R3) and read as zero after reset.
- R8: A request is rejected when req_size_i is not 2'b10 (32-bit), when its low two address bits are nonzero, or when its offset is 0x3C or above. A rejected request changes no state, returns zero read data and sets err_o for the one response cycle.
- R9: rsp_valid_o is 1 exactly one cycle after each request and carries the read data. A program completed by a write is visible to a data-out read issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | BUS_AW | Byte offset into the register window |
| req_size_i | input | 2 | Access size code, 2'b10 = 32-bit |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata_o | output | 32 | Read data, zero for writes and rejected accesses |
| err_o | output | 1 | Rejected-access pulse, aligned with rsp_valid_o |
| prog_err_o | output | 1 | Write-once violation pulse, aligned with rsp_valid_o |

## Verification
The assertions assume at most one request per cycle, with the request fields stable while req_valid_i is high. They also assume the address register does not change in the same cycle as a write-enable strobe, which holds because the window has a single access port. The bench drives one request at a time from a task, holds it for exactly one cycle, and always sets up the address, bit index and data bit with separate writes before the strobe. Rejected accesses are issued as ordinary single requests, so every assertion sees a request pattern that the bus itself could produce.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_SLOTS = 15;
    localparam logic [1:0]  SIZE_WORD = 2'b10;

    typedef enum logic [3:0] {
        SLOT_ADDR     = 4'd0,
        SLOT_BITSEL   = 4'd1,
        SLOT_REDSEL   = 4'd2,
        SLOT_CHIPEN   = 4'd3,
        SLOT_CLKCTL   = 4'd4,
        SLOT_DIN      = 4'd5,
        SLOT_DOUT     = 4'd6,
        SLOT_STROBE   = 4'd7,
        SLOT_PROGCTL  = 4'd8,
        SLOT_TESTCTL  = 4'd9,
        SLOT_TESTMODE = 4'd10,
        SLOT_TESTREP  = 4'd11,
        SLOT_TESTRD   = 4'd12,
        SLOT_TRIM     = 4'd13,
        SLOT_WREN     = 4'd14
    } slot_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] bitsel;
        logic [DATA_W-1:0] redsel;
        logic [DATA_W-1:0] chipen;
        logic [DATA_W-1:0] clkctl;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] strobe;
        logic [DATA_W-1:0] progctl;
        logic [DATA_W-1:0] testctl;
        logic [DATA_W-1:0] testmode;
        logic [DATA_W-1:0] testrep;
        logic [DATA_W-1:0] testrd;
        logic [DATA_W-1:0] trim;
        logic              wren;
    } ctl_regs_t;

    typedef struct packed {
        ctl_regs_t         ctl;
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } rf_state_t;

    typedef struct packed {
        logic prog_err;
    } store_state_t;

endpackage

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
    import otp_fuse_pkg::*;
#(
    parameter int unsigned    WORD_AW     = 12,
    parameter int unsigned    SERIAL_ADDR = 'hFC,
    parameter logic [DATA_W-1:0] SERIAL   = '0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                prog_req_i,
    input  logic [WORD_AW-1:0]  word_idx_i,
    input  logic [4:0]          bit_idx_i,
    input  logic                din_bit_i,
    output logic [DATA_W-1:0]   rd_word_o,
    output logic                prog_err_o
);

    localparam int unsigned        WORDS    = 1 << WORD_AW;
    localparam logic [WORD_AW-1:0] SER_IDX  = SERIAL_ADDR[WORD_AW-1:0];
    localparam logic [WORD_AW-1:0] SER_NEXT = SER_IDX + 1'b1;

    // Burned bit values; only meaningful where the written map is set.
    logic [DATA_W-1:0] data_q [WORDS];
    // Written map: one flag per fuse bit.
    logic [DATA_W-1:0] wmap_q [WORDS];

    store_state_t st_d, st_q;
    logic         tgt_written;
    logic         prog_ok;

    function automatic logic [DATA_W-1:0] base_word(input logic [WORD_AW-1:0] w);
        if (w == SER_IDX) begin
            return SERIAL;
        end else if (w == SER_NEXT) begin
            return ~SERIAL;
        end
        return '1;
    endfunction

    always_comb begin
        tgt_written   = wmap_q[word_idx_i][bit_idx_i];
        prog_ok       = prog_req_i && !tgt_written;
        st_d          = st_q;
        st_d.prog_err = prog_req_i && tgt_written;
        rd_word_o     = (wmap_q[word_idx_i] & data_q[word_idx_i])
                      | (~wmap_q[word_idx_i] & base_word(word_idx_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(WORDS); i++) begin
                wmap_q[i] <= '0;
            end
        end else if (prog_ok) begin
            wmap_q[word_idx_i][bit_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (prog_ok) begin
            data_q[word_idx_i][bit_idx_i] <= din_bit_i;
        end
    end

    assign prog_err_o = st_q.prog_err;

    // R3
    mark_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_req_i && !tgt_written |=> wmap_q[$past(word_idx_i)][$past(bit_idx_i)]);

    // R5
    once_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_req_i && tgt_written |=> prog_err_o && $stable(rd_word_o));

    // R5
    no_false_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !prog_req_i |=> !prog_err_o);

endmodule

// File: rtl/otp_regfile.sv
module otp_regfile
    import otp_fuse_pkg::*;
#(
    parameter int unsigned WORD_AW = 12,
    parameter int unsigned BUS_AW  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [BUS_AW-1:0]  req_addr_i,
    input  logic [1:0]         req_size_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    input  logic [DATA_W-1:0]  fuse_word_i,
    output logic [WORD_AW-1:0] word_idx_o,
    output logic [4:0]         bit_idx_o,
    output logic               din_bit_o,
    output logic               prog_req_o,
    output logic               rsp_valid_o,
    output logic [DATA_W-1:0]  rsp_rdata_o,
    output logic               err_o
);

    localparam logic [DATA_W-1:0] ADDR_MASK  = DATA_W'((64'd1 << WORD_AW) - 64'd1);
    localparam logic [DATA_W-1:0] CLOSED_VAL = 32'h0000_00FF;

    rf_state_t          st_d, st_q;
    logic [3:0]         slot;
    logic               access_ok;
    logic               read_on;
    logic               rd_hit;
    logic               wr_hit;
    logic [DATA_W-1:0]  rd_val;

    always_comb begin
        slot      = req_addr_i[5:2];
        access_ok = (req_size_i == SIZE_WORD)
                 && (req_addr_i[1:0] == 2'b00)
                 && (req_addr_i[BUS_AW-1:6] == '0)
                 && (slot < 4'(NUM_SLOTS));
        rd_hit    = req_valid_i && !req_write_i && access_ok;
        wr_hit    = req_valid_i && req_write_i && access_ok;
        read_on   = st_q.ctl.chipen[0] && st_q.ctl.strobe[0] && st_q.ctl.trim[0];

        case (slot_e'(slot))
            SLOT_ADDR:     rd_val = st_q.ctl.addr;
            SLOT_BITSEL:   rd_val = st_q.ctl.bitsel;
            SLOT_REDSEL:   rd_val = st_q.ctl.redsel;
            SLOT_CHIPEN:   rd_val = st_q.ctl.chipen;
            SLOT_CLKCTL:   rd_val = st_q.ctl.clkctl;
            SLOT_DIN:      rd_val = st_q.ctl.din;
            SLOT_DOUT:     rd_val = read_on ? fuse_word_i : CLOSED_VAL;
            SLOT_STROBE:   rd_val = st_q.ctl.strobe;
            SLOT_PROGCTL:  rd_val = st_q.ctl.progctl;
            SLOT_TESTCTL:  rd_val = st_q.ctl.testctl;
            SLOT_TESTMODE: rd_val = st_q.ctl.testmode;
            SLOT_TESTREP:  rd_val = st_q.ctl.testrep;
            SLOT_TESTRD:   rd_val = st_q.ctl.testrd;
            SLOT_TRIM:     rd_val = st_q.ctl.trim;
            SLOT_WREN:     rd_val = {{(DATA_W-1){1'b0}}, st_q.ctl.wren};
            default:       rd_val = '0;
        endcase

        prog_req_o = wr_hit && (slot_e'(slot) == SLOT_WREN)
                  && req_wdata_i[0] && (st_q.ctl.redsel == '0);

        st_d           = st_q;
        st_d.rsp_valid = req_valid_i;
        st_d.err       = req_valid_i && !access_ok;
        st_d.rdata     = rd_hit ? rd_val : '0;

        if (wr_hit) begin
            case (slot_e'(slot))
                SLOT_ADDR:     st_d.ctl.addr     = req_wdata_i & ADDR_MASK;
                SLOT_BITSEL:   st_d.ctl.bitsel   = req_wdata_i;
                SLOT_REDSEL:   st_d.ctl.redsel   = req_wdata_i;
                SLOT_CHIPEN:   st_d.ctl.chipen   = req_wdata_i;
                SLOT_CLKCTL:   st_d.ctl.clkctl   = req_wdata_i;
                SLOT_DIN:      st_d.ctl.din      = req_wdata_i;
                SLOT_STROBE:   st_d.ctl.strobe   = req_wdata_i;
                SLOT_PROGCTL:  st_d.ctl.progctl  = req_wdata_i;
                SLOT_TESTCTL:  st_d.ctl.testctl  = req_wdata_i;
                SLOT_TESTMODE: st_d.ctl.testmode = req_wdata_i;
                SLOT_TESTREP:  st_d.ctl.testrep  = req_wdata_i;
                SLOT_TESTRD:   st_d.ctl.testrd   = req_wdata_i;
                SLOT_TRIM:     st_d.ctl.trim     = req_wdata_i;
                SLOT_WREN:     st_d.ctl.wren     = req_wdata_i[0];
                default:       st_d.ctl          = st_q.ctl;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_idx_o  = st_q.ctl.addr[WORD_AW-1:0];
    assign bit_idx_o   = st_q.ctl.bitsel[4:0];
    assign din_bit_o   = st_q.ctl.din[0];
    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_rdata_o = st_q.rdata;
    assign err_o       = st_q.err;

    // R1
    dout_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_hit && (slot_e'(slot) == SLOT_DOUT) && !read_on |=> rsp_rdata_o == CLOSED_VAL);

    // R2
    addr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_hit && (slot_e'(slot) == SLOT_ADDR) |=> (rsp_rdata_o & ~ADDR_MASK) == '0);

    // R8
    reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i && !access_ok |=> err_o && rsp_rdata_o == '0 && $stable(st_q.ctl));

    // R9
    rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    // R9
    rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o && !err_o);

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_fuse_pkg::*;
#(
    parameter int unsigned       WORD_AW     = 12,
    parameter int unsigned       BUS_AW      = 8,
    parameter int unsigned       SERIAL_ADDR = 'hFC,
    parameter logic [DATA_W-1:0] SERIAL      = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [BUS_AW-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [31:0]       req_wdata_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o,
    output logic              err_o,
    output logic              prog_err_o
);

    logic [WORD_AW-1:0] word_idx;
    logic [4:0]         bit_idx;
    logic               din_bit;
    logic               prog_req;
    logic [DATA_W-1:0]  fuse_word;

    otp_regfile #(
        .WORD_AW (WORD_AW),
        .BUS_AW  (BUS_AW)
    ) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_size_i  (req_size_i),
        .req_wdata_i (req_wdata_i),
        .fuse_word_i (fuse_word),
        .word_idx_o  (word_idx),
        .bit_idx_o   (bit_idx),
        .din_bit_o   (din_bit),
        .prog_req_o  (prog_req),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .err_o       (err_o)
    );

    otp_fuse_store #(
        .WORD_AW     (WORD_AW),
        .SERIAL_ADDR (SERIAL_ADDR),
        .SERIAL      (SERIAL)
    ) store_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .prog_req_i (prog_req),
        .word_idx_i (word_idx),
        .bit_idx_i  (bit_idx),
        .din_bit_i  (din_bit),
        .rd_word_o  (fuse_word),
        .prog_err_o (prog_err_o)
    );

endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;

    localparam logic [31:0] SER = 32'hA5C3_0F1E;
    localparam logic [7:0] O_ADDR = 8'h00, O_BITSEL = 8'h04, O_REDSEL = 8'h08,
                           O_CHIPEN = 8'h0C, O_CLKCTL = 8'h10, O_DIN = 8'h14,
                           O_DOUT = 8'h18, O_STROBE = 8'h1C, O_PROGCTL = 8'h20,
                           O_TESTCTL = 8'h24, O_TESTMODE = 8'h28, O_TESTREP = 8'h2C,
                           O_TESTRD = 8'h30, O_TRIM = 8'h34, O_WREN = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err;
    logic        prog_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] r_data;
    logic        r_valid, r_err, r_perr;

    always #5 clk = ~clk;

    otp_fuse_ctrl #(.SERIAL(SER)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .err_o(err), .prog_err_o(prog_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_size = 2'b10;
        r_data = rsp_rdata; r_valid = rsp_valid; r_err = err; r_perr = prog_err;
    endtask

    task automatic wr32(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, a, d, 2'b10);
    endtask

    task automatic rd32(input logic [7:0] a);
        access(1'b0, a, 32'h0, 2'b10);
    endtask

    task automatic set_target(input logic [31:0] w, input logic [31:0] b, input logic [31:0] v);
        wr32(O_ADDR, w);
        wr32(O_BITSEL, b);
        wr32(O_DIN, v);
    endtask

    task automatic open_read;
        wr32(O_CHIPEN, 32'h1);
        wr32(O_STROBE, 32'h1);
        wr32(O_TRIM, 32'h1);
    endtask

    task automatic test_reset_state;
        rd32(O_ADDR);
        check("R7 ADDR after reset", r_data, 32'h0);
        check("R9 rsp_valid on read", {31'b0, r_valid}, 32'h1);
        check("R8 no err on legal read", {31'b0, r_err}, 32'h0);
        rd32(O_DOUT);
        check("R1 DOUT closed after reset", r_data, 32'hFF);
        rd32(O_TESTRD);
        check("R7 TESTRD after reset", r_data, 32'h0);
    endtask

    task automatic test_init_content;
        open_read();
        wr32(O_ADDR, 32'hFC);
        rd32(O_DOUT);
        check("R6 serial word", r_data, SER);
        wr32(O_ADDR, 32'hFD);
        rd32(O_DOUT);
        check("R6 complement word", r_data, ~SER);
        wr32(O_ADDR, 32'h005);
        rd32(O_DOUT);
        check("R6 plain word ones", r_data, 32'hFFFF_FFFF);
        wr32(O_ADDR, 32'hFFF);
        rd32(O_DOUT);
        check("R6 last word ones", r_data, 32'hFFFF_FFFF);
    endtask

    task automatic test_gating;
        wr32(O_ADDR, 32'hFC);
        wr32(O_CHIPEN, 32'h0);
        rd32(O_DOUT);
        check("R1 chip-enable clear", r_data, 32'hFF);
        wr32(O_CHIPEN, 32'h1);
        wr32(O_STROBE, 32'hFFFF_FFFE);
        rd32(O_DOUT);
        check("R1 strobe bit0 clear", r_data, 32'hFF);
        wr32(O_STROBE, 32'h1);
        wr32(O_TRIM, 32'h0);
        rd32(O_DOUT);
        check("R1 trim clear", r_data, 32'hFF);
        wr32(O_TRIM, 32'h1);
        rd32(O_DOUT);
        check("R1 all enables set", r_data, SER);
    endtask

    task automatic test_program;
        set_target(32'h5, 32'd3, 32'h0);
        wr32(O_WREN, 32'h1);
        check("R5 no prog_err on first program", {31'b0, r_perr}, 32'h0);
        rd32(O_DOUT);
        check("R3 R9 bit3 cleared, next-cycle read", r_data, 32'hFFFF_FFF7);
        rd32(O_WREN);
        check("R3 WREN readback", r_data, 32'h1);
        wr32(O_DIN, 32'h1);
        wr32(O_WREN, 32'h1);
        check("R5 prog_err on second program", {31'b0, r_perr}, 32'h1);
        rd32(O_DOUT);
        check("R5 word unchanged", r_data, 32'hFFFF_FFF7);
        set_target(32'h5, 32'd0, 32'h1);
        wr32(O_WREN, 32'h1);
        check("R5 program of 1 accepted", {31'b0, r_perr}, 32'h0);
        wr32(O_DIN, 32'h0);
        wr32(O_WREN, 32'h1);
        check("R5 bit0 locked after writing 1", {31'b0, r_perr}, 32'h1);
        rd32(O_DOUT);
        check("R5 bit0 still 1", r_data, 32'hFFFF_FFF7);
        set_target(32'h5, 32'h0000_00FF, 32'h0);
        wr32(O_WREN, 32'h1);
        rd32(O_DOUT);
        check("R3 bit index uses BITSEL[4:0]", r_data, 32'h7FFF_FFF7);
    endtask

    task automatic test_wren_bit0;
        set_target(32'h7, 32'd9, 32'h0);
        wr32(O_WREN, 32'hFFFF_FFFE);
        rd32(O_WREN);
        check("R3 WREN keeps only bit0", r_data, 32'h0);
        rd32(O_DOUT);
        check("R3 no program without bit0", r_data, 32'hFFFF_FFFF);
        wr32(O_WREN, 32'h3);
        rd32(O_DOUT);
        check("R3 program with bit0", r_data, 32'hFFFF_FDFF);
    endtask

    task automatic test_redundancy;
        set_target(32'h6, 32'd4, 32'h0);
        wr32(O_REDSEL, 32'h1);
        wr32(O_WREN, 32'h1);
        check("R4 no prog_err with redsel", {31'b0, r_perr}, 32'h0);
        rd32(O_DOUT);
        check("R4 word unchanged with redsel", r_data, 32'hFFFF_FFFF);
        wr32(O_REDSEL, 32'h0);
        wr32(O_WREN, 32'h1);
        check("R4 bit not marked, program accepted", {31'b0, r_perr}, 32'h0);
        rd32(O_DOUT);
        check("R4 program after redsel cleared", r_data, 32'hFFFF_FFEF);
    endtask

    task automatic test_registers;
        wr32(O_ADDR, 32'hFFFF_F123);
        rd32(O_ADDR);
        check("R2 address masked", r_data, 32'h0000_0123);
        wr32(O_CLKCTL, 32'h1111_2222);
        wr32(O_PROGCTL, 32'h3333_4444);
        wr32(O_TESTCTL, 32'h5555_6666);
        wr32(O_TESTMODE, 32'h7777_8888);
        wr32(O_TESTREP, 32'h9999_AAAA);
        wr32(O_TESTRD, 32'hBBBB_CCCC);
        wr32(O_REDSEL, 32'hDDDD_EEEE);
        rd32(O_CLKCTL);   check("R7 CLKCTL", r_data, 32'h1111_2222);
        rd32(O_PROGCTL);  check("R7 PROGCTL", r_data, 32'h3333_4444);
        rd32(O_TESTCTL);  check("R7 TESTCTL", r_data, 32'h5555_6666);
        rd32(O_TESTMODE); check("R7 TESTMODE", r_data, 32'h7777_8888);
        rd32(O_TESTREP);  check("R7 TESTREP", r_data, 32'h9999_AAAA);
        rd32(O_TESTRD);   check("R7 TESTRD", r_data, 32'hBBBB_CCCC);
        rd32(O_REDSEL);   check("R7 REDSEL", r_data, 32'hDDDD_EEEE);
        wr32(O_REDSEL, 32'h0);
        wr32(O_ADDR, 32'hFC);
        wr32(O_DOUT, 32'h0000_0000);
        check("R7 DOUT write accepted without err", {31'b0, r_err}, 32'h0);
        rd32(O_DOUT);
        check("R7 DOUT write ignored", r_data, SER);
        wr32(O_CHIPEN, 32'hCAFE_0001);
        rd32(O_CHIPEN);
        check("R7 CHIPEN full width", r_data, 32'hCAFE_0001);
    endtask

    task automatic test_reject;
        rd32(8'h3C);
        check("R8 hole read data", r_data, 32'h0);
        check("R8 hole read err", {31'b0, r_err}, 32'h1);
        check("R9 rsp_valid on rejected", {31'b0, r_valid}, 32'h1);
        access(1'b1, O_ADDR, 32'h0000_0AAA, 2'b01);
        check("R8 half-size write err", {31'b0, r_err}, 32'h1);
        rd32(O_ADDR);
        check("R8 half-size write no effect", r_data, 32'h0000_00FC);
        access(1'b1, 8'h01, 32'h0000_0BBB, 2'b10);
        check("R8 misaligned err", {31'b0, r_err}, 32'h1);
        rd32(O_ADDR);
        check("R8 misaligned no effect", r_data, 32'h0000_00FC);
        access(1'b1, 8'h40, 32'h0000_0CCC, 2'b10);
        check("R8 high offset err", {31'b0, r_err}, 32'h1);
        access(1'b0, O_DOUT, 32'h0, 2'b00);
        check("R8 byte read returns zero", r_data, 32'h0);
        rd32(O_ADDR);
        check("R8 err clears after good access", {31'b0, r_err}, 32'h0);
        check("R8 ADDR unchanged", r_data, 32'h0000_00FC);
        set_target(32'h5, 32'd3, 32'h1);
        access(1'b1, O_WREN, 32'h1, 2'b01);
        check("R8 rejected strobe raises no prog_err", {31'b0, r_perr}, 32'h0);
        @(negedge clk);
        check("R9 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_init_content();
        test_gating();
        test_program();
        test_wren_bit0();
        test_redundancy();
        test_registers();
        test_reject();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule